// File: doc/BRIEF.md
# Polynomial Operation Sequencer

This block is the micro-sequencer between a scheme-level controller and a cluster of polynomial ALUs. The controller raises `start` for one cycle with a two-bit function code, a scheme code and a security level. The sequencer then generates the whole polynomial operation on its own. In every issue cycle it drives one ALU opcode, a top and a bottom SRAM read address for each butterfly lane, and a twiddle-ROM index for each lane. The same addresses come back out as write-back addresses after the ALU pipeline latency. When the last write-back has retired, it pulses `done`.

Polynomial length, the number of butterfly layers and the issue cycles per pass all come from the scheme and level codes together with the `BFLY` lane count. A single control path therefore serves every scheme. Forward transforms use a decimation-in-time layer order. Inverse transforms run the layers in the opposite order and end with a scaling pass. An idle gap of `PIPE_LAT` cycles separates consecutive passes, so a pass never reads a word that the previous pass has not yet written back.

Top module: `poly_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `op_valid` and `wr_valid` are 0 and `op` is 0 (no-op).
- R2: Scheme codes are 0 (23-bit modulus lattice signature), 1 (12-bit modulus key exchange), 2 (integer lattice signature) and 3 (hash-based). A `start` seen while idle with scheme 0 to 2 is accepted and raises `busy` in the next cycle. A `start` with scheme 3 is dropped, and the block stays idle.
- R3: N is 256 for schemes 0 and 1, whatever the level. For scheme 2, N is 512 at level 0 and 1024 at any other level.
- R4: Function codes are 0 (sampling setup) and 1 (pointwise multiply-accumulate). Each is a single coefficient pass of N/(2·BFLY) issue cycles. In cycle c, lane l has k = c·BFLY + l, top = 2k, bottom = 2k+1 and twiddle index 0. The opcode is 1 for sampling and 2 for multiply-accumulate.
- R5: Function code 2 (forward NTT) runs L layers: 8 for scheme 0, 7 for scheme 1 and log2 N for scheme 2. Each layer takes N/(2·BFLY) issue cycles with opcode 3. In layer s the half-span is h = N/2^(s+1), top = (k/h)·2h + k mod h and bottom = top + h.
- R6: Lane l's twiddle field sits at bits [l·(AW+3) +: AW+3], where AW = log2 N_MAX. The field is {scheme, inverse bit, index}. For butterflies the index is N/(2h) + k/h. The inverse bit is 1 only for function 3.
- R7: Function code 3 (inverse NTT) runs the same L layers with opcode 4 and half-span h = (N/2^L)·2^s. These are followed by one scaling pass with opcode 5, coefficient addressing as in R4 and twiddle index 0.
- R8: Between consecutive passes there are exactly `PIPE_LAT` cycles with `op_valid` = 0 and `op` = 0.
- R9: `wr_valid`, `wr_top` and `wr_bot` repeat `op_valid`, `rd_top` and `rd_bot` from exactly `PIPE_LAT` cycles earlier.
- R10: `done` is high for one cycle, `PIPE_LAT`+1 cycles after the last issue cycle. `busy` is 0 in the cycle after `done`.
- R11: A `start` seen while `busy` is high, including the `done` cycle, is ignored: the running operation keeps its exact stream, and no new operation begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a function |
| func | input | 2 | Function code (R4, R5, R7) |
| scheme | input | 2 | Scheme code (R2) |
| level | input | 2 | Security level (R3) |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| op_valid | output | 1 | Issue cycle: opcode and read addresses are meaningful |
| op | output | 3 | ALU opcode, 0 when not issuing |
| rd_top | output | BFLY·AW | Per-lane top (first) read address |
| rd_bot | output | BFLY·AW | Per-lane bottom (second) read address |
| tw_idx | output | BFLY·(AW+3) | Per-lane twiddle-ROM index {scheme, inverse, index} |
| wr_valid | output | 1 | Write-back cycle |
| wr_top | output | BFLY·AW | Per-lane top write-back address |
| wr_bot | output | BFLY·AW | Per-lane bottom write-back address |

## Verification
The main function is exercised with each function code on each lattice scheme. Every issue cycle is compared lane by lane against an address model built from the requirement formulas. Forward and inverse transforms on schemes 0 and 1 share N but differ in layer count, so they separate the 8-layer and 7-layer bounds and the growing and shrinking half-span orders. Scheme 2 at two levels shows that the level selects N and the number of layers, and a level change on scheme 0 shows that it has no effect there. Start pulses in the middle of a run, in the done cycle and with the hash-based scheme code exercise the rejection paths.

// File: rtl/poly_seq_pkg.sv
// Shared codes for the polynomial operation sequencer.
package poly_seq_pkg;

    // Function codes issued by the scheme-level controller.
    typedef enum logic [1:0] {
        FN_SAMPLE = 2'd0,
        FN_MAC    = 2'd1,
        FN_NTT    = 2'd2,
        FN_INTT   = 2'd3
    } fn_e;

    // Scheme codes.
    typedef enum logic [1:0] {
        SCH_Q23   = 2'd0,
        SCH_Q12   = 2'd1,
        SCH_NTRU  = 2'd2,
        SCH_HASH  = 2'd3
    } sch_e;

    // ALU opcodes driven each issue cycle.
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_SAMPLE = 3'd1,
        OP_MAC    = 3'd2,
        OP_BF_CT  = 3'd3,
        OP_BF_GS  = 3'd4,
        OP_SCALE  = 3'd5
    } op_e;

    // Sequencer control states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

endpackage

// File: rtl/poly_seq_cfg.sv
// Decodes scheme, level and function code into loop bounds.
// Assumes the caller latches the results only when accept is high.
module poly_seq_cfg
    import poly_seq_pkg::*;
(
    input  fn_e         func,
    input  sch_e        scheme,
    input  logic [1:0]  level,
    output logic        accept,
    output logic [3:0]  nlog,
    output logic [3:0]  layers,
    output logic [3:0]  npass
);

    // Select log2 N, the layer count and the pass count.
    always_comb begin
        accept = (scheme != SCH_HASH);
        case (scheme)
            SCH_Q12:  begin nlog = 4'd8; layers = 4'd7; end
            SCH_NTRU: begin
                nlog   = (level == 2'd0) ? 4'd9 : 4'd10;
                layers = nlog;
            end
            default:  begin nlog = 4'd8; layers = 4'd8; end
        endcase
        case (func)
            FN_NTT:  npass = layers;
            FN_INTT: npass = layers + 4'd1;
            default: npass = 4'd1;
        endcase
    end

endmodule

// File: rtl/poly_seq_ctrl.sv
// Pass/cycle/gap state machine. Assumes BFLY is a power of two with
// BFLY <= N/2 for every N it runs, and PIPE_LAT >= 1.
module poly_seq_ctrl
    import poly_seq_pkg::*;
#(
    parameter int BFLY     = 4,
    parameter int PIPE_LAT = 3,
    parameter int AW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_ok,
    input  fn_e           func_in,
    input  sch_e          scheme_in,
    input  logic [3:0]    cfg_nlog,
    input  logic [3:0]    cfg_layers,
    input  logic [3:0]    cfg_npass,
    output logic          issue,
    output logic          busy,
    output logic          done,
    output fn_e           func_q,
    output sch_e          scheme_q,
    output logic [3:0]    nlog_q,
    output logic [3:0]    layers_q,
    output logic [3:0]    pass_q,
    output logic [AW-1:0] cyc_q
);

    localparam int LB = $clog2(BFLY);
    localparam int WW = $clog2(PIPE_LAT + 1);

    st_e             st;
    logic [3:0]      npass_q;
    logic [WW-1:0]   wcnt;
    logic [AW-1:0]   cyc_max;
    logic            cyc_last;

    // Last issue cycle of a pass: N/(2*BFLY) - 1.
    always_comb begin
        cyc_max  = AW'((32'd1 << (32'(nlog_q) - 32'd1 - 32'(LB))) - 32'd1);
        cyc_last = (cyc_q == cyc_max);
    end

    // State, counters and latched configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            func_q   <= FN_SAMPLE;
            scheme_q <= SCH_Q23;
            nlog_q   <= 4'd8;
            layers_q <= 4'd8;
            npass_q  <= 4'd1;
            pass_q   <= 4'd0;
            cyc_q    <= '0;
            wcnt     <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start && cfg_ok) begin
                    st       <= ST_ISSUE;
                    func_q   <= func_in;
                    scheme_q <= scheme_in;
                    nlog_q   <= cfg_nlog;
                    layers_q <= cfg_layers;
                    npass_q  <= cfg_npass;
                    pass_q   <= 4'd0;
                    cyc_q    <= '0;
                end
                ST_ISSUE: if (cyc_last) begin
                    st     <= ST_WAIT;
                    cyc_q  <= '0;
                    wcnt   <= '0;
                    pass_q <= pass_q + 4'd1;
                end else begin
                    cyc_q <= cyc_q + AW'(1);
                end
                ST_WAIT: if (wcnt == WW'(PIPE_LAT - 1)) begin
                    st <= (pass_q == npass_q) ? ST_DONE : ST_ISSUE;
                end else begin
                    wcnt <= wcnt + WW'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign issue = (st == ST_ISSUE);
    assign busy  = (st != ST_IDLE);
    assign done  = (st == ST_DONE);

    // R10: completion is a single-cycle pulse.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: latched function stays fixed while the run is active.
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(func_q) && $stable(nlog_q)));

    // R2: a hash-scheme request leaves the sequencer idle.
    a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !cfg_ok) |=> !busy);

endmodule

// File: rtl/poly_seq_addr.sv
// Per-lane address, twiddle and opcode generation for one issue cycle.
// Assumes the pass/cycle inputs come from poly_seq_ctrl.
module poly_seq_addr
    import poly_seq_pkg::*;
#(
    parameter int BFLY = 4,
    parameter int AW   = 10
) (
    input  logic                   valid,
    input  fn_e                    func,
    input  sch_e                   scheme,
    input  logic [3:0]             nlog,
    input  logic [3:0]             layers,
    input  logic [3:0]             pass,
    input  logic [AW-1:0]          cyc,
    output op_e                    op,
    output logic [BFLY*AW-1:0]     rd_top,
    output logic [BFLY*AW-1:0]     rd_bot,
    output logic [BFLY*(AW+3)-1:0] tw_idx
);

    localparam int LB  = $clog2(BFLY);
    localparam int TWW = AW + 3;

    logic       is_coef;
    logic       inv;
    logic [3:0] hlog;

    // Pass kind, inverse flag, half-span exponent and opcode.
    always_comb begin
        inv     = (func == FN_INTT);
        is_coef = (func == FN_SAMPLE) || (func == FN_MAC) ||
                  (inv && (pass == layers));
        if (func == FN_NTT) hlog = nlog - 4'd1 - pass;
        else                hlog = nlog - layers + pass;
        if (!valid) op = OP_NOP;
        else case (func)
            FN_SAMPLE: op = OP_SAMPLE;
            FN_MAC:    op = OP_MAC;
            FN_NTT:    op = OP_BF_CT;
            default:   op = is_coef ? OP_SCALE : OP_BF_GS;
        endcase
    end

    for (genvar g = 0; g < BFLY; g++) begin : g_lane
        logic [AW-1:0] k, blk, half, off, top, bot, idx;
        // Butterfly or coefficient addressing for lane g.
        always_comb begin
            k    = (cyc << LB) | AW'(g);
            half = AW'(1) << hlog;
            blk  = k >> hlog;
            off  = k & (half - AW'(1));
            if (!valid) begin
                top = '0; bot = '0; idx = '0;
            end else if (is_coef) begin
                top = k << 1;
                bot = top | AW'(1);
                idx = '0;
            end else begin
                top = (blk << (hlog + 4'd1)) | off;
                bot = top | half;
                idx = (AW'(1) << (nlog - 4'd1 - hlog)) + blk;
            end
        end
        assign rd_top[g*AW +: AW]   = top;
        assign rd_bot[g*AW +: AW]   = bot;
        assign tw_idx[g*TWW +: TWW] = valid ? {scheme, inv, idx} : '0;
    end

endmodule

// File: rtl/poly_seq_wb.sv
// Delay line that turns read addresses into write-back addresses.
// Assumes DEPTH >= 1.
module poly_seq_wb #(
    parameter int W     = 80,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    logic [DEPTH:0] v;
    logic [W-1:0]   d [DEPTH+1];

    assign v[0] = in_valid;
    assign d[0] = in_data;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        // One register stage of the write-back delay.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v[s+1] <= 1'b0;
                d[s+1] <= '0;
            end else begin
                v[s+1] <= v[s];
                d[s+1] <= d[s];
            end
        end
    end

    assign out_valid = v[DEPTH];
    assign out_data  = d[DEPTH];

endmodule

// File: rtl/poly_seq.sv
// Polynomial operation sequencer top: decodes a function request, issues
// per-lane opcodes, read addresses and twiddle indices, delays them into
// write-back addresses, and pulses done after the last write-back.
// Assumes N_MAX >= 1024, BFLY a power of two up to 128, PIPE_LAT >= 1.
module poly_seq
    import poly_seq_pkg::*;
#(
    parameter int BFLY     = 4,
    parameter int PIPE_LAT = 3,
    parameter int N_MAX    = 1024
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic [1:0]                            func,
    input  logic [1:0]                            scheme,
    input  logic [1:0]                            level,
    output logic                                  busy,
    output logic                                  done,
    output logic                                  op_valid,
    output logic [2:0]                            op,
    output logic [BFLY*$clog2(N_MAX)-1:0]         rd_top,
    output logic [BFLY*$clog2(N_MAX)-1:0]         rd_bot,
    output logic [BFLY*($clog2(N_MAX)+3)-1:0]     tw_idx,
    output logic                                  wr_valid,
    output logic [BFLY*$clog2(N_MAX)-1:0]         wr_top,
    output logic [BFLY*$clog2(N_MAX)-1:0]         wr_bot
);

    localparam int AW = $clog2(N_MAX);
    localparam int LW = BFLY * AW;

    logic          cfg_ok;
    logic [3:0]    cfg_nlog, cfg_layers, cfg_npass;
    fn_e           func_q;
    sch_e          scheme_q;
    logic [3:0]    nlog_q, layers_q, pass_q;
    logic [AW-1:0] cyc_q;
    op_e           op_w;
    logic [2*LW-1:0] wb_data;

    poly_seq_cfg u_cfg (
        .func   (fn_e'(func)),
        .scheme (sch_e'(scheme)),
        .level  (level),
        .accept (cfg_ok),
        .nlog   (cfg_nlog),
        .layers (cfg_layers),
        .npass  (cfg_npass)
    );

    poly_seq_ctrl #(.BFLY(BFLY), .PIPE_LAT(PIPE_LAT), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_ok     (cfg_ok),
        .func_in    (fn_e'(func)),
        .scheme_in  (sch_e'(scheme)),
        .cfg_nlog   (cfg_nlog),
        .cfg_layers (cfg_layers),
        .cfg_npass  (cfg_npass),
        .issue      (op_valid),
        .busy       (busy),
        .done       (done),
        .func_q     (func_q),
        .scheme_q   (scheme_q),
        .nlog_q     (nlog_q),
        .layers_q   (layers_q),
        .pass_q     (pass_q),
        .cyc_q      (cyc_q)
    );

    poly_seq_addr #(.BFLY(BFLY), .AW(AW)) u_addr (
        .valid  (op_valid),
        .func   (func_q),
        .scheme (scheme_q),
        .nlog   (nlog_q),
        .layers (layers_q),
        .pass   (pass_q),
        .cyc    (cyc_q),
        .op     (op_w),
        .rd_top (rd_top),
        .rd_bot (rd_bot),
        .tw_idx (tw_idx)
    );

    assign op = op_w;

    poly_seq_wb #(.W(2*LW), .DEPTH(PIPE_LAT)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (op_valid),
        .in_data   ({rd_top, rd_bot}),
        .out_valid (wr_valid),
        .out_data  (wb_data)
    );

    assign wr_top = wb_data[2*LW-1:LW];
    assign wr_bot = wb_data[LW-1:0];

    // R5: lane-0 addresses stay inside the active polynomial.
    a_r5_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (((rd_top[AW-1:0] >> nlog_q) == '0) &&
                      ((rd_bot[AW-1:0] >> nlog_q) == '0)));

    // R10: done follows the final write-back and no write is pending.
    a_r10_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_valid && !op_valid && $past(wr_valid)));

endmodule

// File: tb/poly_seq_tb.sv
// Directed bench for poly_seq: one task per scenario, model from requirements.
module poly_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int B    = 4;
    localparam int PIPE = 3;
    localparam int NMAX = 1024;
    localparam int AW   = 10;
    localparam int TWW  = AW + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] func = 2'd0, scheme = 2'd0, level = 2'd0;
    logic busy, done, op_valid, wr_valid;
    logic [2:0] op;
    logic [B*AW-1:0] rd_top, rd_bot, wr_top, wr_bot;
    logic [B*TWW-1:0] tw_idx;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poly_seq #(.BFLY(B), .PIPE_LAT(PIPE), .N_MAX(NMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func),
        .scheme(scheme), .level(level), .busy(busy), .done(done),
        .op_valid(op_valid), .op(op), .rd_top(rd_top), .rd_bot(rd_bot),
        .tw_idx(tw_idx), .wr_valid(wr_valid), .wr_top(wr_top), .wr_bot(wr_bot)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected fields of one lane in one issue cycle, from R4..R7.
    function automatic void exp_lane(input int fn, input int L, input int n,
                                     input int p, input int c, input int l,
                                     output int top, output int bot,
                                     output int idx, output int opc);
        int k, h;
        k = c * B + l;
        if (fn < 2 || (fn == 3 && p == L)) begin
            top = 2 * k; bot = 2 * k + 1; idx = 0;
            opc = (fn == 0) ? 1 : (fn == 1) ? 2 : 5;
        end else begin
            if (fn == 2) h = n / (2 ** (p + 1));
            else         h = (n / (2 ** L)) * (2 ** p);
            top = (k / h) * 2 * h + (k % h);
            bot = top + h;
            idx = n / (2 * h) + k / h;
            opc = (fn == 2) ? 3 : 4;
        end
    endfunction

    // Run one function and compare every cycle; optional start pokes (R11).
    task automatic run_fn(input int fn, input int sch, input int lvl,
                          input int poke_cyc, input bit poke_done);
        int nlog, L, npass, P, n, mode, p, c, w, t, nis;
        bit fin;
        int hv [16];
        logic [B*AW-1:0] ht [16];
        logic [B*AW-1:0] hb [16];
        string rq;
        nlog = (sch == 2) ? ((lvl == 0) ? 9 : 10) : 8;
        n = 2 ** nlog;
        L = (sch == 1) ? 7 : nlog;
        npass = (fn < 2) ? 1 : (fn == 2) ? L : L + 1;
        P = n / (2 * B);
        @(negedge clk);
        func = 2'(fn); scheme = 2'(sch); level = 2'(lvl); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mode = 0; p = 0; c = 0; w = 0; t = 0; nis = 0; fin = 0;
        while (!fin && t < 20000) begin
            hv[t % 16] = op_valid; ht[t % 16] = rd_top; hb[t % 16] = rd_bot;
            check(busy === 1'b1, "R2", busy, 1);
            if (mode == 0) begin
                check(op_valid === 1'b1 && done === 1'b0, "R8", op_valid, 1);
                nis++;
                for (int l = 0; l < B; l++) begin
                    int et, eb, ei, eo, etw;
                    exp_lane(fn, L, n, p, c, l, et, eb, ei, eo);
                    rq = (fn < 2 || (fn == 3 && p == L)) ? "R4" : (fn == 2) ? "R5" : "R7";
                    etw = sch * (2 ** (AW + 1)) + ((fn == 3) ? 2 ** AW : 0) + ei;
                    check(int'(op) == eo, rq, int'(op), eo);
                    check(int'(rd_top[l*AW +: AW]) == et, rq, int'(rd_top[l*AW +: AW]), et);
                    check(int'(rd_bot[l*AW +: AW]) == eb, rq, int'(rd_bot[l*AW +: AW]), eb);
                    check(int'(tw_idx[l*TWW +: TWW]) == etw, "R6", int'(tw_idx[l*TWW +: TWW]), etw);
                end
                c++;
                if (c == P) begin
                    c = 0; p++; w = 0;
                    mode = (p == npass) ? 2 : 1;
                end
            end else if (mode == 1 || mode == 2) begin
                check(op_valid === 1'b0 && op === 3'd0, "R8", op_valid, 0);
                check(done === 1'b0, "R10", done, 0);
                w++;
                if (w == PIPE) mode = (mode == 1) ? 0 : 3;
            end else begin
                check(done === 1'b1, "R10", done, 1);
                fin = 1;
            end
            if (t >= PIPE) begin
                check(wr_valid === 1'(hv[(t - PIPE) % 16]), "R9", wr_valid, hv[(t - PIPE) % 16]);
                if (hv[(t - PIPE) % 16] != 0) begin
                    check(wr_top == ht[(t - PIPE) % 16], "R9", int'(wr_top[AW-1:0]), int'(ht[(t - PIPE) % 16][AW-1:0]));
                    check(wr_bot == hb[(t - PIPE) % 16], "R9", int'(wr_bot[AW-1:0]), int'(hb[(t - PIPE) % 16][AW-1:0]));
                end
            end else begin
                check(wr_valid === 1'b0, "R9", wr_valid, 0);
            end
            if (!fin) begin
                if (t == poke_cyc) begin
                    start = 1'b1; func = 2'(3 - fn); scheme = 2'd2; level = 2'd1;
                end else start = 1'b0;
                @(negedge clk);
                t++;
            end
        end
        check(nis == npass * P, (poke_cyc >= 0) ? "R11" : "R5", nis, npass * P);
        start = poke_done;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b0 && done === 1'b0, "R10", busy, 0);
        @(negedge clk);
        check(busy === 1'b0 && op_valid === 1'b0, poke_done ? "R11" : "R10", busy, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1", busy, 0);
        check(op_valid === 1'b0 && wr_valid === 1'b0 && op === 3'd0, "R1", op_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && op_valid === 1'b0, "R1", busy, 0);
    endtask

    task automatic t_hash_reject();
        @(negedge clk);
        func = 2'd2; scheme = 2'd3; level = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(busy === 1'b0 && op_valid === 1'b0, "R2", busy, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        run_fn(0, 0, 0, -1, 0);   // R4 sampling, scheme 0
        run_fn(1, 1, 2, -1, 0);   // R4 MAC, scheme 1, level ignored (R3)
        run_fn(2, 0, 0, 40, 0);   // R5 8-layer NTT, mid-run start (R11)
        run_fn(2, 0, 3, -1, 0);   // R3 level has no effect on scheme 0
        run_fn(2, 1, 0, -1, 1);   // R5 7-layer NTT, start in done cycle (R11)
        run_fn(3, 0, 0, -1, 0);   // R7 8-layer INTT with scaling
        run_fn(3, 1, 1, 100, 0);  // R7 7-layer INTT
        run_fn(2, 2, 0, -1, 0);   // R3 N = 512
        run_fn(3, 2, 1, -1, 0);   // R3 N = 1024, R7
        t_hash_reject();          // R2
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule